// File: doc/BRIEF.md
# Floating-Point Load Address and Format Unit

This unit runs one floating-point load at a time. For each operation it receives an operation code, two 64-bit general register values (the base RA and the index RB), a flag that says whether the RA register number is zero, and a 16-bit displacement. From these it computes an effective address and sends a single 4-byte or 8-byte read on a request/response memory port. It then turns the returned data into a 64-bit floating-point register value.

The read data can be placed in the result in four ways. A single-precision word is widened to double format, and denormals are normalized during the widening. A double-word is passed through unchanged. A 32-bit integer word is either sign-extended or zero-extended to 64 bits. The update variants also return the effective address as a write-back value for RA. The result, the write-back and a one-cycle done strobe all appear in the same cycle. The unit accepts a new operation only while it is idle.

Top module: `fpload_unit`

## Requirements
- R1: After reset is released, busy, mem_req_valid, done and ra_wb_en are all low.
- R2: When op_code[2] is 0 (immediate form), the effective address is base + sign-extended disp, computed modulo 2^64.
- R3: When op_code[2] is 1 (indexed form), the effective address is base + rb_val, computed modulo 2^64.
- R4: In a non-update operation with ra_is_zero high, the base is zero and ra_val is ignored. In a non-update operation with ra_is_zero low, the base is ra_val.
- R5: op_code[3] selects the update variant, and it applies only to the two floating-point kinds (op_code[1:0] of 00 or 01). In an update operation the base is always ra_val, whatever ra_is_zero says, and ra_wb_en is high with ra_wb_data equal to the effective address in the done cycle. For the integer-word kinds op_code[3] has no effect: ra_wb_en stays low and the base follows R4.
- R6: The read request holds mem_req_size 0 (4 bytes) for kinds 00, 10 and 11, and 1 (8 bytes) for kind 01. mem_req_valid, mem_req_addr and mem_req_size stay stable until mem_req_ready is seen. A 4-byte read takes its data from mem_rsp_data[31:0] and ignores bits [63:32].
- R7: Kind 00 (single) widens the word to double format. A normal number keeps its sign, adds 896 to its exponent and appends 29 zero fraction bits. Zeros, infinities and NaNs keep their sign and class, and their fraction is extended in the same way.
- R8: Kind 00 with a denormal input (exponent field 0, fraction nonzero) produces a normalized double with the same numerical value.
- R9: Kind 01 (double) writes all 64 response bits to frt_data unchanged.
- R10: Kind 10 sign-extends the 32-bit word to 64 bits.
- R11: Kind 11 places the 32-bit word in bits [31:0] and clears bits [63:32].
- R12: An operation is accepted only when op_valid is high while busy is low. Busy stays high from the cycle after acceptance through the done cycle. done lasts exactly one cycle. op_valid raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | [1:0] kind, [2] indexed, [3] update |
| ra_val | input | 64 | Base register contents |
| ra_is_zero | input | 1 | RA register number is zero |
| rb_val | input | 64 | Index register contents |
| disp | input | 16 | Signed displacement |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 1 | 0: 4 bytes, 1: 8 bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Result valid strobe |
| frt_data | output | 64 | Floating-point register result |
| ra_wb_en | output | 1 | RA write-back enable |
| ra_wb_data | output | 64 | RA write-back value |

## Verification
The effective address is captured at acceptance and is shown on mem_req_addr one cycle later. A wrong base choice, a wrong offset choice or a wrong sign extension therefore appears at the port before the memory has answered. The same register drives ra_wb_data, so an update operation shows the same error again in its done cycle. Mistakes in the format path appear only in frt_data, one cycle after the response beat, so each widening class, denormal position and integer-word kind is tested with its own data word. A control state that gets stuck appears as busy never falling, or as done lasting two cycles. The bench checks both after every operation.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

    localparam int XLEN   = 64;
    localparam int SP_W   = 32;
    localparam int SP_EXP = 8;
    localparam int SP_FRC = SP_W - SP_EXP - 1;
    localparam int DP_EXP = 11;
    localparam int DP_FRC = XLEN - DP_EXP - 1;
    localparam int FRC_PAD = DP_FRC - SP_FRC;

    typedef enum logic [1:0] {
        KIND_SP = 2'b00,
        KIND_DP = 2'b01,
        KIND_WS = 2'b10,
        KIND_WZ = 2'b11
    } load_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } unit_state_e;

    typedef struct packed {
        unit_state_e       state;
        logic [XLEN-1:0]   ea;
        load_kind_e        kind;
        logic              upd;
        logic [XLEN-1:0]   frt;
    } unit_regs_t;

endpackage

// File: rtl/fpl_ea_gen.sv
module fpl_ea_gen
    import fpl_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic [XLEN-1:0]   ra_val,
    input  logic              ra_is_zero,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              force_ra,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] base_w;
    logic [XLEN-1:0] offs_w;

    always_comb begin
        // Register-zero rule only applies to non-update forms
        base_w = (ra_is_zero && !force_ra) ? '0 : ra_val;
        offs_w = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
        ea     = base_w + offs_w;
    end

endmodule

// File: rtl/fpl_sp_widen.sv
module fpl_sp_widen
    import fpl_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output logic [XLEN-1:0] dp_out
);
    localparam logic [DP_EXP-1:0] REBIAS   = DP_EXP'(896);
    localparam logic [DP_EXP-1:0] DEN_BASE = DP_EXP'(874);
    localparam int                POS_W    = $clog2(SP_FRC + 1);

    logic                sgn;
    logic [SP_EXP-1:0]   exp_in;
    logic [SP_FRC-1:0]   frc_in;
    logic [POS_W-1:0]    msb_pos;
    logic [POS_W-1:0]    shamt;
    logic [SP_FRC:0]     norm_w;
    logic [DP_EXP-1:0]   exp_out;
    logic [SP_FRC-1:0]   frc_out;

    always_comb begin
        sgn    = sp_in[SP_W-1];
        exp_in = sp_in[SP_W-2 -: SP_EXP];
        frc_in = sp_in[SP_FRC-1:0];

        // Leading-one position for denormal normalization
        msb_pos = '0;
        for (int i = 0; i < SP_FRC; i++) begin
            if (frc_in[i]) msb_pos = POS_W'(i);
        end
        shamt  = POS_W'(SP_FRC) - msb_pos;
        norm_w = {1'b0, frc_in} << shamt;

        if (exp_in == '1) begin
            exp_out = '1;
            frc_out = frc_in;
        end else if (exp_in == '0) begin
            if (frc_in == '0) begin
                exp_out = '0;
                frc_out = '0;
            end else begin
                exp_out = DEN_BASE + DP_EXP'(msb_pos);
                frc_out = norm_w[SP_FRC-1:0];
            end
        end else begin
            exp_out = {{(DP_EXP-SP_EXP){1'b0}}, exp_in} + REBIAS;
            frc_out = frc_in;
        end

        dp_out = {sgn, exp_out, frc_out, {FRC_PAD{1'b0}}};
    end

endmodule

// File: rtl/fpl_result_fmt.sv
module fpl_result_fmt
    import fpl_pkg::*;
(
    input  load_kind_e      kind,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] frt
);
    localparam int HI_W = XLEN - SP_W;

    logic [SP_W-1:0] word_w;
    logic [XLEN-1:0] widened_w;

    assign word_w = raw[SP_W-1:0];

    fpl_sp_widen u_widen (
        .sp_in  (word_w),
        .dp_out (widened_w)
    );

    always_comb begin
        unique case (kind)
            KIND_SP: frt = widened_w;
            KIND_DP: frt = raw;
            KIND_WS: frt = {{HI_W{word_w[SP_W-1]}}, word_w};
            KIND_WZ: frt = {{HI_W{1'b0}}, word_w};
            default: frt = raw;
        endcase
    end

endmodule

// File: rtl/fpload_unit.sv
module fpload_unit
    import fpl_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [XLEN-1:0]   ra_val,
    input  logic              ra_is_zero,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [DISP_W-1:0] disp,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic              mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              done,
    output logic [XLEN-1:0]   frt_data,
    output logic              ra_wb_en,
    output logic [XLEN-1:0]   ra_wb_data
);

    unit_regs_t      r_q, r_d;
    load_kind_e      in_kind_w;
    logic            in_upd_w;
    logic [XLEN-1:0] ea_w;
    logic [XLEN-1:0] fmt_w;

    assign in_kind_w = load_kind_e'(op_code[1:0]);
    // Update applies only to the floating-point kinds
    assign in_upd_w  = op_code[3] && !op_code[1];

    fpl_ea_gen #(.DISP_W(DISP_W)) u_ea (
        .ra_val     (ra_val),
        .ra_is_zero (ra_is_zero),
        .rb_val     (rb_val),
        .disp       (disp),
        .indexed    (op_code[2]),
        .force_ra   (in_upd_w),
        .ea         (ea_w)
    );

    fpl_result_fmt u_fmt (
        .kind (r_q.kind),
        .raw  (mem_rsp_data),
        .frt  (fmt_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    r_d.state = ST_REQ;
                    r_d.ea    = ea_w;
                    r_d.kind  = in_kind_w;
                    r_d.upd   = in_upd_w;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.frt   = fmt_w;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ea: '0, kind: KIND_SP, upd: 1'b0, frt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.state != ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_REQ);
    assign mem_req_addr  = r_q.ea;
    assign mem_req_size  = (r_q.kind == KIND_DP);
    assign done          = (r_q.state == ST_DONE);
    assign frt_data      = r_q.frt;
    assign ra_wb_en      = done && r_q.upd;
    assign ra_wb_data    = r_q.ea;

    // R12: accepted op leads straight to a request
    a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> (busy && mem_req_valid));

    // R12: done is a single-cycle strobe followed by idle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R12: busy does not drop before done
    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: request held stable until taken
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)));

    // R6: request only while busy and never with done
    a_r6_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (busy && !done));

    // R5: write-back only together with done
    a_r5_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ra_wb_en |-> done);

    // R1: reset leaves the unit quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req_valid && !done && !ra_wb_en));

endmodule

// File: tb/fpload_unit_bench.sv
`timescale 1ns/1ps
module fpload_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [63:0] ra_val;
    logic        ra_is_zero;
    logic [63:0] rb_val;
    logic [15:0] disp;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_req_size;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic [63:0] frt_data;
    logic        ra_wb_en;
    logic [63:0] ra_wb_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    fpload_unit u_fpload_unit (
        .clk, .rst_n, .op_valid, .op_code, .ra_val, .ra_is_zero, .rb_val,
        .disp, .busy, .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_req_size, .mem_rsp_valid, .mem_rsp_data, .done, .frt_data,
        .ra_wb_en, .ra_wb_data
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent reference: shift-loop normalization
    function automatic logic [63:0] widen_ref(input logic [31:0] w);
        logic [7:0]  e;
        logic [23:0] m;
        int          x;
        e = w[30:23];
        m = {1'b0, w[22:0]};
        if (e == 8'hFF) return {w[31], 11'h7FF, w[22:0], 29'b0};
        if (e == 8'h00 && m == 0) return {w[31], 63'b0};
        if (e == 8'h00) begin
            x = 897;
            while (m[23] == 1'b0) begin
                m = m << 1;
                x = x - 1;
            end
            return {w[31], x[10:0], m[22:0], 29'b0};
        end
        x = int'(e) - 127 + 1023;
        return {w[31], x[10:0], w[22:0], 29'b0};
    endfunction

    logic [63:0] got_addr, got_frt, got_wb;
    logic        got_size, got_wb_en;

    // One load: drive op, serve the memory, capture results
    task automatic run_op(input logic [3:0] code, input logic [63:0] ra, input logic raz,
                          input logic [63:0] rb, input logic [15:0] d, input logic [63:0] rsp,
                          input int rdy_dly, input int rsp_dly, input logic intrude);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; ra_val = ra; ra_is_zero = raz; rb_val = rb; disp = d;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R12 busy after accept", 64'(busy), 64'd1);
        chk("R6 req valid", 64'(mem_req_valid), 64'd1);
        got_addr = mem_req_addr;
        got_size = mem_req_size;
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            chk("R6 req held", 64'(mem_req_valid), 64'd1);
            chk("R6 addr stable", mem_req_addr, got_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R6 req dropped", 64'(mem_req_valid), 64'd0);
        if (intrude) begin
            op_valid = 1'b1; op_code = 4'b0101; ra_val = 64'hAAAA; ra_is_zero = 1'b0;
        end
        for (int i = 0; i < rsp_dly; i++) begin
            @(negedge clk);
            chk("R12 busy in wait", 64'(busy), 64'd1);
            chk("R12 no early done", 64'(done), 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = rsp;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; op_valid = 1'b0;
        chk("R12 done", 64'(done), 64'd1);
        chk("R12 busy in done", 64'(busy), 64'd1);
        got_frt = frt_data; got_wb_en = ra_wb_en; got_wb = ra_wb_data;
        @(negedge clk);
        chk("R12 done one cycle", 64'(done), 64'd0);
        chk("R12 idle after done", 64'(busy), 64'd0);
        chk("R12 no stray request", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 req", 64'(mem_req_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 wb", 64'(ra_wb_en), 64'd0);
    endtask

    task automatic t_imm_addr;
        run_op(4'b0000, 64'h1000, 1'b0, 64'h0, 16'hFFF0, 64'h0, 0, 0, 1'b0);
        chk("R2 negative disp", got_addr, 64'hFF0);
        chk("R6 size single", 64'(got_size), 64'd0);
        run_op(4'b0000, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 64'h0, 16'h0010, 64'h0, 1, 1, 1'b0);
        chk("R2 wrap", got_addr, 64'h8);
        chk("R5 no wb non-update", 64'(got_wb_en), 64'd0);
    endtask

    task automatic t_idx_addr;
        run_op(4'b0101, 64'h2000, 1'b0, 64'h30, 16'h8000, 64'h0123_4567_89AB_CDEF, 2, 0, 1'b0);
        chk("R3 indexed", got_addr, 64'h2030);
        chk("R6 size double", 64'(got_size), 64'd1);
        chk("R9 double passthrough", got_frt, 64'h0123_4567_89AB_CDEF);
        run_op(4'b0100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h2, 16'h0, 64'h0, 0, 0, 1'b0);
        chk("R3 indexed wrap", got_addr, 64'h1);
    endtask

    task automatic t_ra_zero;
        run_op(4'b0000, 64'h5555, 1'b1, 64'h0, 16'hFFFC, 64'h0, 0, 0, 1'b0);
        chk("R4 zero base imm", got_addr, 64'hFFFF_FFFF_FFFF_FFFC);
        run_op(4'b0111, 64'h5555, 1'b1, 64'h40, 16'h0, 64'h0, 0, 0, 1'b0);
        chk("R4 zero base idx", got_addr, 64'h40);
        run_op(4'b0111, 64'h5555, 1'b0, 64'h40, 16'h0, 64'h0, 0, 0, 1'b0);
        chk("R4 ra base idx", got_addr, 64'h5595);
    endtask

    task automatic t_update;
        run_op(4'b1001, 64'h100, 1'b1, 64'h0, 16'h0008, 64'h0, 0, 0, 1'b0);
        chk("R5 update uses ra", got_addr, 64'h108);
        chk("R5 wb en", 64'(got_wb_en), 64'd1);
        chk("R5 wb data", got_wb, 64'h108);
        run_op(4'b1100, 64'h7000, 1'b0, 64'hFFFF_FFFF_FFFF_FF00, 16'h0, 64'h0, 1, 0, 1'b0);
        chk("R5 wb indexed", got_wb, 64'h6F00);
        chk("R5 wb en indexed", 64'(got_wb_en), 64'd1);
        run_op(4'b1010, 64'h900, 1'b1, 64'h0, 16'h0004, 64'h0, 0, 0, 1'b0);
        chk("R5 word ignores update base", got_addr, 64'h4);
        chk("R5 word no wb", 64'(got_wb_en), 64'd0);
    endtask

    task automatic t_sp_classes;
        logic [31:0] pats [6] = '{32'h3F80_0000, 32'hC020_0000, 32'h0000_0000,
                                  32'h8000_0000, 32'h7F80_0000, 32'h7FC0_0001};
        for (int i = 0; i < 6; i++) begin
            run_op(4'b0000, 64'h0, 1'b0, 64'h0, 16'h0, {32'hDEAD_BEEF, pats[i]}, i % 2, i % 3, 1'b0);
            chk("R7 widen", got_frt, widen_ref(pats[i]));
        end
        run_op(4'b0000, 64'h0, 1'b0, 64'h0, 16'h0, 64'h3F80_0000, 0, 0, 1'b0);
        chk("R7 one", got_frt, 64'h3FF0_0000_0000_0000);
    endtask

    task automatic t_sp_denorm;
        logic [31:0] pats [4] = '{32'h0000_0001, 32'h8040_0000, 32'h007F_FFFF, 32'h0000_0300};
        for (int i = 0; i < 4; i++) begin
            run_op(4'b0100, 64'h0, 1'b0, 64'h0, 16'h0, {32'h1234_5678, pats[i]}, 0, 1, 1'b0);
            chk("R8 denormal", got_frt, widen_ref(pats[i]));
        end
        run_op(4'b0000, 64'h0, 1'b0, 64'h0, 16'h0, 64'h1, 0, 0, 1'b0);
        chk("R8 smallest", got_frt, 64'h36A0_0000_0000_0000);
    endtask

    task automatic t_words;
        run_op(4'b0110, 64'h0, 1'b0, 64'h0, 16'h0, 64'h0000_0000_8000_0000, 0, 0, 1'b0);
        chk("R10 negative word", got_frt, 64'hFFFF_FFFF_8000_0000);
        chk("R6 size word", 64'(got_size), 64'd0);
        run_op(4'b0110, 64'h0, 1'b0, 64'h0, 16'h0, 64'hFFFF_FFFF_7FFF_FFFF, 0, 2, 1'b0);
        chk("R10 positive word", got_frt, 64'h0000_0000_7FFF_FFFF);
        run_op(4'b0111, 64'h0, 1'b0, 64'h0, 16'h0, 64'hABCD_0000_FFFF_FFFF, 1, 0, 1'b0);
        chk("R11 zero extend", got_frt, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_busy_ignore;
        run_op(4'b0010, 64'h300, 1'b0, 64'h0, 16'h0010, 64'h0000_0000_0000_0042, 1, 3, 1'b1);
        chk("R12 first op address", got_addr, 64'h310);
        chk("R12 first op result kept", got_frt, 64'h42);
        chk("R12 intruding op no wb", 64'(got_wb_en), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; ra_val = '0; ra_is_zero = 1'b0;
        rb_val = '0; disp = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm_addr();
        t_idx_addr();
        t_ra_zero();
        t_update();
        t_sp_classes();
        t_sp_denorm();
        t_words();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule